// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that advances on an instruction-rate tick enable. A prescaler divides the tick by 1, 4 or 16. The counter runs from 00h up to a programmable period value and returns to 00h on the increment that follows, instead of moving past the period.

Each return to 00h produces a one-cycle match pulse. That pulse is exported so a serial block can use it as a shift or baud clock. The same pulse also feeds a postscaler with ratios 1 to 16, and the postscaler sets a sticky interrupt flag.

Software reaches the counter, the period and the control register through a small register port with address, write strobe, write data and combinational read data.

Top module: `pm_timer`

## Requirements
- R1: After reset the counter reads 00h, the period reads FFh, the control register reads 00h, the flag is 0 and the match output is 0.
- R2: While enabled, each prescaled step adds one to the counter. When the counter equals the period, the step loads 00h instead and raises `match_pulse` for exactly the cycle after that edge.
- R3: With the period at 00h, every prescaled step produces a match pulse and the counter stays at 00h.
- R4: Control bits [1:0] choose the prescale ratio: 00 gives 1, 01 gives 4, and 10 or 11 give 16 ticks per counter step.
- R5: Control bits [6:3] hold a value N. The flag is set on every (N+1)-th match pulse, in the same cycle as that pulse.
- R6: The address map is 0 for the counter, 1 for the period, 2 for control, and 3 reads 00h. Control bit 7 always reads 0.
- R7: A write to the counter or to the control register clears the prescale and postscale counts. A control write leaves the counter value unchanged.
- R8: The flag stays set until `flag_clr` is asserted. If a set and a clear happen in the same cycle, the set wins.
- R9: With control bit 2 at 0, the counter and prescale count hold, and no match pulse or flag set occurs.
- R10: A write to the counter loads the written value, and counting continues from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Instruction-rate count enable |
| reg_addr | input | 2 | Register select |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| flag_clr | input | 1 | Clears the interrupt flag |
| match_pulse | output | 1 | One-cycle pulse on counter wrap, before the postscaler |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The embedded assertions check properties that must hold on every cycle:
- a match pulse always leaves the counter at 00h;
- a control write keeps the counter value;
- no match pulse appears unless the timer was enabled;
- the flag holds until it is cleared;
- the counter never skips values.

Some behaviours depend on a particular programmed setup and only the bench scenarios can show them. These are the prescale and postscale ratios, the clearing of the partial counts by register writes, the case where set beats clear, and the period-zero case. The bench compares the design against a cycle model driven by random register traffic, and adds directed cases for these settings.

// File: rtl/pm_timer.sv
module pm_timer #(
  parameter int CW = 8,
  parameter int AW = 2,
  parameter logic [CW-1:0] PER_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  input  logic          flag_clr,
  output logic          match_pulse,
  output logic          irq_flag
);
  localparam logic [AW-1:0] A_CNT = 0, A_PER = 1, A_CTL = 2;
  localparam int PSW = 4;

  logic [CW-1:0]  cnt, per;
  logic [6:0]     ctl;
  logic [PSW-1:0] pre, post, pre_last;
  logic           on, wr_cnt, wr_ctl, step, wrap, post_hit;

  assign on       = ctl[2];
  assign wr_cnt   = reg_we && reg_addr == A_CNT;
  assign wr_ctl   = reg_we && reg_addr == A_CTL;
  assign pre_last = ctl[1] ? 4'd15 : (ctl[0] ? 4'd3 : 4'd0);
  assign step     = tick && on && !wr_cnt && !wr_ctl && pre == pre_last;
  assign wrap     = step && cnt == per;
  assign post_hit = wrap && post == ctl[6:3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; per <= PER_RST; ctl <= '0; pre <= '0; post <= '0;
      match_pulse <= 1'b0; irq_flag <= 1'b0;
    end else begin
      match_pulse <= wrap;
      if (wr_cnt || wr_ctl) begin
        pre <= '0; post <= '0;
      end else begin
        if (tick && on) pre <= (pre == pre_last) ? '0 : pre + 1'b1;
        if (wrap) post <= post_hit ? '0 : post + 1'b1;
      end
      if (wr_cnt) cnt <= reg_wdata;
      else if (step) cnt <= wrap ? '0 : cnt + 1'b1;
      if (reg_we && reg_addr == A_PER) per <= reg_wdata;
      if (wr_ctl) ctl <= reg_wdata[6:0];
      if (post_hit) irq_flag <= 1'b1;
      else if (flag_clr) irq_flag <= 1'b0;
    end

  always_comb
    case (reg_addr)
      A_CNT:   reg_rdata = cnt;
      A_PER:   reg_rdata = per;
      A_CTL:   reg_rdata = {1'b0, ctl};
      default: reg_rdata = '0;
    endcase

  p_match_at_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> cnt == '0);
  p_ctl_keeps_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ctl) |-> cnt == $past(cnt));
  p_off_no_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(on));
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_flag) && !$past(flag_clr)) |-> irq_flag);
  p_no_skip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_cnt) |-> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt == '0));
  p_bit7_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == A_CTL |-> !reg_rdata[7]);
endmodule

// File: tb/sim_pm_timer.sv
module sim_pm_timer;
  localparam time PERIOD = 10;
  logic clk = 0, rst_n = 0, tick = 0, reg_we = 0, flag_clr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic match_pulse, irq_flag;
  int tests = 0, fails = 0;

  logic [7:0] m_cnt = 0, m_per = 8'hFF;
  logic [6:0] m_ctl = 0;
  int m_pre = 0, m_post = 0;
  bit m_match = 0, m_flag = 0;

  always #(PERIOD/2) clk = ~clk;

  pm_timer u0 (.clk, .rst_n, .tick, .reg_addr, .reg_we, .reg_wdata,
               .reg_rdata, .flag_clr, .match_pulse, .irq_flag);

  function automatic int ratio(logic [6:0] c);
    return c[1] ? 16 : (c[0] ? 4 : 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle();
    bit wcnt, wctl, adv, wr;
    wcnt = reg_we && reg_addr == 0;
    wctl = reg_we && reg_addr == 2;
    wr = 0;
    if (wcnt || wctl) begin
      m_pre = 0; m_post = 0;
    end else if (tick && m_ctl[2]) begin
      adv = (m_pre + 1 == ratio(m_ctl));
      m_pre = adv ? 0 : m_pre + 1;
      if (adv) begin
        if (m_cnt == m_per) begin
          m_cnt = 0; wr = 1;
        end else m_cnt = m_cnt + 1;
      end
    end
    m_match = wr;
    if (wr) begin
      if (m_post == int'(m_ctl[6:3])) begin m_post = 0; m_flag = 1; end
      else begin m_post = m_post + 1; if (flag_clr) m_flag = 0; end
    end else if (flag_clr) m_flag = 0;
    if (wcnt) m_cnt = reg_wdata;
    if (reg_we && reg_addr == 1) m_per = reg_wdata;
    if (wctl) m_ctl = reg_wdata[6:0];
    @(posedge clk); #1;
    check(match_pulse == m_match, "R2 match", match_pulse, m_match);
    check(irq_flag == m_flag, "R5 flag", irq_flag, m_flag);
    @(negedge clk);
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_we = 1; reg_wdata = d; cycle(); reg_we = 0;
  endtask

  task automatic rd_check(logic [1:0] a, logic [7:0] exp, string req);
    reg_addr = a; #1;
    check(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  initial begin
    #(PERIOD*200000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #(PERIOD*3); @(negedge clk); rst_n = 1; #1;
    rd_check(0, 8'h00, "R1 cnt"); rd_check(1, 8'hFF, "R1 per");
    rd_check(2, 8'h00, "R1 ctl");
    check(!irq_flag && !match_pulse, "R1 outs", irq_flag, 0);
    @(negedge clk);
    // R6 bit 7 and unused address
    wr_reg(2, 8'hF8); rd_check(2, 8'h78, "R6 ctl"); rd_check(3, 8'h00, "R6 addr3");
    // R3 period zero, prescale 1, postscale 1
    wr_reg(1, 8'h00); wr_reg(2, 8'h04); tick = 1;
    for (int i = 0; i < 6; i++) begin
      cycle(); check(match_pulse, "R3 every tick", match_pulse, 1);
      rd_check(0, 8'h00, "R3 cnt");
    end
    // R8 set wins over clear
    flag_clr = 1; cycle();
    check(irq_flag, "R8 set wins", irq_flag, 1);
    tick = 0; cycle(); check(!irq_flag, "R8 cleared", irq_flag, 0);
    flag_clr = 0;
    // R4 prescale 4: step after 4 ticks
    wr_reg(1, 8'h10); wr_reg(2, 8'h05); tick = 1;
    for (int i = 0; i < 3; i++) cycle();
    rd_check(0, 8'h00, "R4 before");
    cycle(); rd_check(0, 8'h01, "R4 step");
    // R4 prescale 16 (code 11)
    wr_reg(2, 8'h07);
    for (int i = 0; i < 15; i++) cycle();
    rd_check(0, 8'h01, "R4 x16 hold"); cycle(); rd_check(0, 8'h02, "R4 x16 step");
    // R10 load, R7 control write clears prescale, keeps counter
    wr_reg(0, 8'h0E); wr_reg(2, 8'h05); rd_check(0, 8'h0E, "R7 keep cnt");
    tick = 1; cycle(); cycle(); cycle(); wr_reg(2, 8'h05);
    for (int i = 0; i < 3; i++) cycle();
    rd_check(0, 8'h0E, "R7 pre cleared"); cycle(); rd_check(0, 8'h0F, "R10 counts on");
    // R9 disabled holds
    wr_reg(2, 8'h00);
    for (int i = 0; i < 20; i++) begin
      cycle(); check(!match_pulse, "R9 no match", match_pulse, 0);
    end
    rd_check(0, 8'h0F, "R9 hold");
    // R5 postscale 1:3 with period 1
    wr_reg(1, 8'h01); wr_reg(0, 8'h00); wr_reg(2, 8'h14); flag_clr = 1; cycle(); flag_clr = 0;
    for (int i = 0; i < 12; i++) cycle();
    // random traffic against the model (R2, R5, R7, R8, R10)
    for (int i = 0; i < 20000; i++) begin
      tick = ($urandom % 4) != 0;
      flag_clr = ($urandom % 40) == 0;
      reg_we = ($urandom % 25) == 0;
      reg_addr = 2'($urandom % 4);
      reg_wdata = (reg_addr == 1) ? 8'($urandom % 8) : 8'($urandom);
      if (reg_addr == 2) reg_wdata[2] = ($urandom % 5) != 0;
      cycle();
      rd_check(0, m_cnt, "R2 cnt");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule